// File: doc/BRIEF.md
# DSP Load/Store Address Unit

This unit executes the memory-transfer instructions of a 16-bit fixed-point DSP. It takes one instruction word at a time, forms the data-memory or program-memory address, starts the access, and writes the result into the 32-entry register file it holds. Indirect forms then adjust the address register they used. Short forms build the address from the low byte of a control register and an 8-bit immediate. The instruction-memory form moves a program word into an accumulator's middle word.

The register file is also reachable from the rest of the core through a plain write port and a registered read port. Loads that land in an accumulator middle word may widen the value across the whole accumulator, depending on a mode bit in the status register. Data and program memories sit outside the unit and are synchronous, with one cycle of read latency.

Top module: `dsp_ldst_unit`

## Requirements
- R1: After reset `ready` is 1, no memory strobe (`dm_re`, `dm_we`, `im_re`) is active, and all 32 registers read 0.
- R2: Opcode `0010_0ddd_iiii_iiii` (short load) reads data memory at address {register 0x12 bits 7:0, iiii_iiii} and writes the word to register 0x18+ddd.
- R3: Opcode `0010_1sss_iiii_iiii` (short store) writes register 0x18+sss to data memory at address {register 0x12 bits 7:0, iiii_iiii}.
- R4: Opcode `0001_1uuL_0aar_rrrr` is an indirect transfer through address register aa (registers 0 to 3): L=0 loads register rrrrr from data memory, L=1 stores register rrrrr to data memory.
- R5: The post-update field uu (indirect) or bits 3:2 (program load) selects 00 unchanged, 01 minus one, 10 plus one, 11 plus index register 4+aa taken as signed; all arithmetic wraps modulo 65536.
- R6: The memory access uses the address register value from before the post-update; when the destination is the address register itself and the update is not 00, the update result is kept.
- R7: Opcode `0000_001c_0000_uuaa` reads program memory at address register aa and writes register 0x1E+c (accumulator c middle word), with the R5 update applied to aa.
- R8: When status register 0x13 bit 14 is 1, a load into register 0x1E+c also sets register 0x10+c to 16 copies of the loaded bit 15 and clears register 0x1C+c; when that bit is 0 only the middle word changes.
- R9: The memory strobe is a single-cycle pulse in the cycle after acceptance, the register write and address update occur two cycles after acceptance, and `ready` is low for exactly those two cycles.
- R10: An opcode matching none of the R2, R3, R4, R7 patterns (including R4 and R7 shapes with a nonzero bit that must be 0) is ignored: no strobe, `ready` stays 1, no register changes.
- R11: `rf_we` writes `rf_wdata` into register `rf_waddr`; `rf_rdata` returns register `rf_raddr` one cycle after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Instruction word present; taken when `ready` is 1 |
| op_word | input | 16 | Instruction word |
| ready | output | 1 | Unit idle and able to take an instruction |
| dm_re | output | 1 | Data-memory read strobe |
| dm_we | output | 1 | Data-memory write strobe |
| dm_addr | output | 16 | Data-memory address |
| dm_wdata | output | 16 | Data-memory write data |
| dm_rdata | input | 16 | Data-memory read data, valid one cycle after `dm_re` |
| im_re | output | 1 | Program-memory read strobe |
| im_addr | output | 16 | Program-memory address |
| im_rdata | input | 16 | Program-memory read data, valid one cycle after `im_re` |
| rf_we | input | 1 | External register write enable |
| rf_waddr | input | 5 | External register write index |
| rf_wdata | input | 16 | External register write data |
| rf_raddr | input | 5 | External register read index |
| rf_rdata | output | 16 | External register read data, registered |

## Verification
The assertions take for granted that `op_valid` is only raised for a single cycle while `ready` is high and that both memories answer exactly one cycle after their strobe. They also assume nothing else writes through the external port during the two busy cycles. The stimulus follows this: each instruction is driven on a falling edge while the unit is idle and withdrawn after one rising edge. External writes are made only between instructions. The bench memory models return data with one cycle of latency and keep stored words so later loads observe them.

// File: rtl/dsp_ldst_pkg.sv
package dsp_ldst_pkg;

  localparam int OP_W   = 16;
  localparam int RIDX_W = 5;

  localparam logic [RIDX_W-1:0] R_IX0  = 5'h04;
  localparam logic [RIDX_W-1:0] R_ACH0 = 5'h10;
  localparam logic [RIDX_W-1:0] R_CR   = 5'h12;
  localparam logic [RIDX_W-1:0] R_SR   = 5'h13;
  localparam logic [RIDX_W-1:0] R_AXB  = 5'h18;
  localparam logic [RIDX_W-1:0] R_ACL0 = 5'h1C;
  localparam logic [RIDX_W-1:0] R_ACM0 = 5'h1E;

  typedef enum logic [2:0] {
    K_NONE, K_SLOAD, K_SSTORE, K_ILOAD, K_ISTORE, K_PLOAD
  } kind_e;

  typedef enum logic [1:0] {
    U_KEEP = 2'b00, U_DEC = 2'b01, U_INC = 2'b10, U_IDX = 2'b11
  } upd_e;

  typedef struct packed {
    kind_e             kind;
    upd_e              upd;
    logic [1:0]        ar;
    logic [RIDX_W-1:0] rsel;
    logic [7:0]        imm;
  } dec_t;

  function automatic logic kind_loads(kind_e k);
    return (k == K_SLOAD) || (k == K_ILOAD) || (k == K_PLOAD);
  endfunction

  function automatic logic kind_updates(kind_e k);
    return (k == K_ILOAD) || (k == K_ISTORE) || (k == K_PLOAD);
  endfunction

endpackage

// File: rtl/dsp_ldst_decode.sv
module dsp_ldst_decode
  import dsp_ldst_pkg::*;
(
  input  logic [OP_W-1:0] op,
  output dec_t            dec
);

  always_comb begin
    dec.kind = K_NONE;
    dec.upd  = U_KEEP;
    dec.ar   = 2'd0;
    dec.rsel = '0;
    dec.imm  = op[7:0];
    if (op[15:11] == 5'b00100) begin
      dec.kind = K_SLOAD;
      dec.rsel = R_AXB | RIDX_W'(op[10:8]);
    end else if (op[15:11] == 5'b00101) begin
      dec.kind = K_SSTORE;
      dec.rsel = R_AXB | RIDX_W'(op[10:8]);
    end else if (op[15:11] == 5'b00011 && !op[7]) begin
      dec.kind = op[8] ? K_ISTORE : K_ILOAD;
      dec.upd  = upd_e'(op[10:9]);
      dec.ar   = op[6:5];
      dec.rsel = op[4:0];
    end else if (op[15:9] == 7'b0000001 && op[7:4] == 4'b0000) begin
      dec.kind = K_PLOAD;
      dec.upd  = upd_e'(op[3:2]);
      dec.ar   = op[1:0];
      dec.rsel = R_ACM0 | RIDX_W'(op[8]);
    end
  end

endmodule

// File: rtl/dsp_ldst_agu.sv
module dsp_ldst_agu
  import dsp_ldst_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int IMM_W  = 8
) (
  input  kind_e                    kind,
  input  upd_e                     upd,
  input  logic [DATA_W-1:0]        ar_val,
  input  logic [DATA_W-1:0]        ix_val,
  input  logic [DATA_W-IMM_W-1:0]  cr_lo,
  input  logic [IMM_W-1:0]         imm,
  output logic [DATA_W-1:0]        eff_addr,
  output logic [DATA_W-1:0]        next_ar
);

  logic short_form;
  assign short_form = (kind == K_SLOAD) || (kind == K_SSTORE);
  assign eff_addr   = short_form ? {cr_lo, imm} : ar_val;

  // two's complement add covers the signed index and the modulo wrap
  always_comb begin
    unique case (upd)
      U_DEC:   next_ar = ar_val - DATA_W'(1);
      U_INC:   next_ar = ar_val + DATA_W'(1);
      U_IDX:   next_ar = ar_val + ix_val;
      default: next_ar = ar_val;
    endcase
  end

endmodule

// File: rtl/dsp_ldst_regfile.sv
module dsp_ldst_regfile
  import dsp_ldst_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int HI_W    = 8,
  parameter int SXM_BIT = 14
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [1:0]          ar_sel,
  input  logic [RIDX_W-1:0]   src_sel,
  input  logic [RIDX_W-1:0]   ext_raddr,
  output logic [DATA_W-1:0]   ar_val,
  output logic [DATA_W-1:0]   ix_val,
  output logic [DATA_W-1:0]   src_val,
  output logic [HI_W-1:0]     cr_lo,
  output logic [DATA_W-1:0]   ext_rdata,
  input  logic                wb_en,
  input  logic [RIDX_W-1:0]   wb_idx,
  input  logic [DATA_W-1:0]   wb_data,
  input  logic                upd_en,
  input  logic [1:0]          upd_sel,
  input  logic [DATA_W-1:0]   upd_data,
  input  logic                ext_we,
  input  logic [RIDX_W-1:0]   ext_waddr,
  input  logic [DATA_W-1:0]   ext_wdata
);

  localparam int NREG = 1 << RIDX_W;

  logic [DATA_W-1:0] regs [NREG];
  logic [DATA_W-1:0] nxt  [NREG];

  logic              mid_hit;
  logic              widen;
  logic [RIDX_W-1:0] hi_idx;
  logic [RIDX_W-1:0] lo_idx;

  assign mid_hit = wb_en && (wb_idx[RIDX_W-1:1] == R_ACM0[RIDX_W-1:1]);
  assign widen   = mid_hit && regs[R_SR][SXM_BIT];
  assign hi_idx  = R_ACH0 | RIDX_W'(wb_idx[0]);
  assign lo_idx  = R_ACL0 | RIDX_W'(wb_idx[0]);

  assign ar_val  = regs[RIDX_W'(ar_sel)];
  assign ix_val  = regs[R_IX0 | RIDX_W'(ar_sel)];
  assign src_val = regs[src_sel];
  assign cr_lo   = regs[R_CR][HI_W-1:0];

  // priority: external port < widening < write-back < address update
  always_comb begin
    for (int g = 0; g < NREG; g++) begin
      nxt[g] = regs[g];
      if (ext_we && ext_waddr == RIDX_W'(g))
        nxt[g] = ext_wdata;
      if (widen && hi_idx == RIDX_W'(g))
        nxt[g] = {DATA_W{wb_data[DATA_W-1]}};
      if (widen && lo_idx == RIDX_W'(g))
        nxt[g] = '0;
      if (wb_en && wb_idx == RIDX_W'(g))
        nxt[g] = wb_data;
      if (upd_en && RIDX_W'(upd_sel) == RIDX_W'(g))
        nxt[g] = upd_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int g = 0; g < NREG; g++) regs[g] <= '0;
      ext_rdata <= '0;
    end else begin
      for (int g = 0; g < NREG; g++) regs[g] <= nxt[g];
      ext_rdata <= regs[ext_raddr];
    end
  end

endmodule

// File: rtl/dsp_ldst_unit.sv
module dsp_ldst_unit
  import dsp_ldst_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int IMM_W   = 8,
  parameter int SXM_BIT = 14
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                op_valid,
  input  logic [OP_W-1:0]     op_word,
  output logic                ready,
  output logic                dm_re,
  output logic                dm_we,
  output logic [DATA_W-1:0]   dm_addr,
  output logic [DATA_W-1:0]   dm_wdata,
  input  logic [DATA_W-1:0]   dm_rdata,
  output logic                im_re,
  output logic [DATA_W-1:0]   im_addr,
  input  logic [DATA_W-1:0]   im_rdata,
  input  logic                rf_we,
  input  logic [RIDX_W-1:0]   rf_waddr,
  input  logic [DATA_W-1:0]   rf_wdata,
  input  logic [RIDX_W-1:0]   rf_raddr,
  output logic [DATA_W-1:0]   rf_rdata
);

  localparam int HI_W = DATA_W - IMM_W;

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_DATA} state_e;

  state_e            state;
  dec_t              dec;
  kind_e             op_kind;
  kind_e             kind_q;
  upd_e              upd_q;
  logic [1:0]        ar_q;
  logic [RIDX_W-1:0] rsel_q;
  logic [DATA_W-1:0] next_ar_q;

  logic [DATA_W-1:0] ar_val, ix_val, src_val, eff_addr, next_ar;
  logic [HI_W-1:0]   cr_lo;
  logic              accept;
  logic              wb_en, upd_en;
  logic [DATA_W-1:0] wb_data;

  dsp_ldst_decode u_dec (.op(op_word), .dec(dec));
  assign op_kind = dec.kind;

  dsp_ldst_regfile #(.DATA_W(DATA_W), .HI_W(HI_W), .SXM_BIT(SXM_BIT)) u_rf (
    .clk(clk), .rst(rst),
    .ar_sel(dec.ar), .src_sel(dec.rsel), .ext_raddr(rf_raddr),
    .ar_val(ar_val), .ix_val(ix_val), .src_val(src_val), .cr_lo(cr_lo),
    .ext_rdata(rf_rdata),
    .wb_en(wb_en), .wb_idx(rsel_q), .wb_data(wb_data),
    .upd_en(upd_en), .upd_sel(ar_q), .upd_data(next_ar_q),
    .ext_we(rf_we), .ext_waddr(rf_waddr), .ext_wdata(rf_wdata)
  );

  dsp_ldst_agu #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_agu (
    .kind(dec.kind), .upd(dec.upd), .ar_val(ar_val), .ix_val(ix_val),
    .cr_lo(cr_lo), .imm(dec.imm[IMM_W-1:0]),
    .eff_addr(eff_addr), .next_ar(next_ar)
  );

  assign ready  = (state == ST_IDLE);
  assign accept = ready && op_valid && (dec.kind != K_NONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      kind_q    <= K_NONE;
      upd_q     <= U_KEEP;
      ar_q      <= '0;
      rsel_q    <= '0;
      next_ar_q <= '0;
      dm_re     <= 1'b0;
      dm_we     <= 1'b0;
      im_re     <= 1'b0;
      dm_addr   <= '0;
      im_addr   <= '0;
      dm_wdata  <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (accept) begin
          kind_q    <= dec.kind;
          upd_q     <= dec.upd;
          ar_q      <= dec.ar;
          rsel_q    <= dec.rsel;
          next_ar_q <= next_ar;
          dm_addr   <= eff_addr;
          im_addr   <= eff_addr;
          dm_wdata  <= src_val;
          dm_re     <= (dec.kind == K_SLOAD) || (dec.kind == K_ILOAD);
          dm_we     <= (dec.kind == K_SSTORE) || (dec.kind == K_ISTORE);
          im_re     <= (dec.kind == K_PLOAD);
          state     <= ST_REQ;
        end
        ST_REQ: begin
          dm_re <= 1'b0;
          dm_we <= 1'b0;
          im_re <= 1'b0;
          state <= ST_DATA;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign wb_en   = (state == ST_DATA) && kind_loads(kind_q);
  assign wb_data = (kind_q == K_PLOAD) ? im_rdata : dm_rdata;
  assign upd_en  = (state == ST_DATA) && kind_updates(kind_q) && (upd_q != U_KEEP);

endmodule

// File: rtl/dsp_ldst_chk.sv
module dsp_ldst_chk
  import dsp_ldst_pkg::*;
(
  input logic  clk,
  input logic  rst,
  input logic  op_valid,
  input logic  ready,
  input logic  dm_re,
  input logic  dm_we,
  input logic  im_re,
  input kind_e op_kind
);

  logic strobe;
  assign strobe = dm_re || dm_we || im_re;

  assert_one_strobe_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({dm_re, dm_we, im_re}));

  assert_strobe_follows_accept_R9: assert property (@(posedge clk) disable iff (rst)
    strobe |-> ($past(op_valid && ready) && !ready));

  assert_strobe_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    strobe |=> !strobe);

  assert_busy_window_R9: assert property (@(posedge clk) disable iff (rst)
    strobe |=> (!ready ##1 ready));

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    ready |-> !strobe);

  assert_unknown_ignored_R10: assert property (@(posedge clk) disable iff (rst)
    (ready && op_valid && op_kind == K_NONE) |=> (ready && !strobe));

endmodule

bind dsp_ldst_unit dsp_ldst_chk u_chk (
  .clk(clk), .rst(rst), .op_valid(op_valid), .ready(ready),
  .dm_re(dm_re), .dm_we(dm_we), .im_re(im_re), .op_kind(op_kind)
);

// File: tb/dsp_ldst_unit_test.sv
module dsp_ldst_unit_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_valid = 1'b0;
  logic [15:0] op_word = '0;
  logic        ready;
  logic        dm_re, dm_we, im_re;
  logic [15:0] dm_addr, dm_wdata, im_addr;
  logic [15:0] dm_rdata = '0;
  logic [15:0] im_rdata = '0;
  logic        rf_we = 1'b0;
  logic [4:0]  rf_waddr = '0;
  logic [15:0] rf_wdata = '0;
  logic [4:0]  rf_raddr = '0;
  logic [15:0] rf_rdata;

  int total = 0;
  int bad   = 0;

  logic [15:0] m [32];
  logic [15:0] dstore [logic [15:0]];
  logic        st_chk;
  logic [15:0] st_addr, st_data;

  dsp_ldst_unit uut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_word(op_word), .ready(ready),
    .dm_re(dm_re), .dm_we(dm_we), .dm_addr(dm_addr), .dm_wdata(dm_wdata),
    .dm_rdata(dm_rdata), .im_re(im_re), .im_addr(im_addr), .im_rdata(im_rdata),
    .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
    .rf_raddr(rf_raddr), .rf_rdata(rf_rdata)
  );

  always #5 clk = ~clk;

  function automatic logic [15:0] dm_val(logic [15:0] a);
    if (dstore.exists(a)) return dstore[a];
    return (a ^ 16'h3C96) + {a[7:0], a[15:8]};
  endfunction

  function automatic logic [15:0] im_val(logic [15:0] a);
    return ~{a[3:0], a[15:4]};
  endfunction

  always @(posedge clk) begin
    if (dm_re) dm_rdata <= dm_val(dm_addr);
    if (dm_we) dstore[dm_addr] = dm_wdata;
    if (im_re) im_rdata <= im_val(im_addr);
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: run did not finish act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  function automatic logic [15:0] op_sld(int d, logic [7:0] imm);
    return {5'b00100, 3'(d), imm};
  endfunction
  function automatic logic [15:0] op_sst(int s, logic [7:0] imm);
    return {5'b00101, 3'(s), imm};
  endfunction
  function automatic logic [15:0] op_ind(int mode, int st, int ar, int r);
    return {5'b00011, 2'(mode), 1'(st), 1'b0, 2'(ar), 5'(r)};
  endfunction
  function automatic logic [15:0] op_pld(int acc, int mode, int ar);
    return {7'b0000001, 1'(acc), 4'b0000, 2'(mode), 2'(ar)};
  endfunction

  task automatic chk(input string tag, input string what, input logic [15:0] act,
                     input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  task automatic set_reg(input int idx, input logic [15:0] v);
    @(negedge clk);
    rf_we = 1'b1; rf_waddr = 5'(idx); rf_wdata = v;
    @(posedge clk);
    @(negedge clk);
    rf_we = 1'b0;
    m[idx] = v;
  endtask

  task automatic get_reg(input int idx, output logic [15:0] v);
    @(negedge clk);
    rf_raddr = 5'(idx);
    @(posedge clk);
    @(negedge clk);
    v = rf_rdata;
  endtask

  task automatic verify_regs(input string tag);
    logic [15:0] v;
    for (int i = 0; i < 32; i++) begin
      get_reg(i, v);
      chk(tag, $sformatf("reg%0d", i), v, m[i]);
    end
  endtask

  // model: write with the accumulator widening rule
  task automatic mwr(input int idx, input logic [15:0] v);
    logic sx;
    sx = m[19][14] && (idx == 30 || idx == 31);
    m[idx] = v;
    if (sx) begin
      m[16 + idx - 30] = v[15] ? 16'hFFFF : 16'h0000;
      m[28 + idx - 30] = 16'h0000;
    end
  endtask

  task automatic mupd(input int arn, input int mode, input logic [15:0] base);
    case (mode)
      1: m[arn] = base - 16'd1;
      2: m[arn] = base + 16'd1;
      3: m[arn] = base + m[4 + arn];
      default: ;
    endcase
  endtask

  task automatic model_exec(input logic [15:0] op);
    logic [15:0] a;
    int arn;
    st_chk = 1'b0;
    if (op[15:11] == 5'b00100) begin
      a = {m[18][7:0], op[7:0]};
      mwr(24 + int'(op[10:8]), dm_val(a));
    end else if (op[15:11] == 5'b00101) begin
      a = {m[18][7:0], op[7:0]};
      st_chk = 1'b1; st_addr = a; st_data = m[24 + int'(op[10:8])];
    end else if (op[15:11] == 5'b00011 && !op[7]) begin
      arn = int'(op[6:5]);
      a = m[arn];
      if (op[8]) begin
        st_chk = 1'b1; st_addr = a; st_data = m[int'(op[4:0])];
      end else begin
        mwr(int'(op[4:0]), dm_val(a));
      end
      if (op[10:9] != 2'b00) mupd(arn, int'(op[10:9]), a);
    end else if (op[15:9] == 7'b0000001 && op[7:4] == 4'b0000) begin
      arn = int'(op[1:0]);
      a = m[arn];
      mwr(30 + int'(op[8]), im_val(a));
      if (op[3:2] != 2'b00) mupd(arn, int'(op[3:2]), a);
    end
  endtask

  task automatic run_op(input logic [15:0] op);
    int guard;
    @(negedge clk);
    guard = 0;
    while (!ready && guard < 20) begin @(negedge clk); guard++; end
    op_valid = 1'b1; op_word = op;
    @(posedge clk);
    @(negedge clk);
    op_valid = 1'b0;
    guard = 0;
    while (!ready && guard < 20) begin @(negedge clk); guard++; end
  endtask

  task automatic run_check(input logic [15:0] op, input string tag);
    model_exec(op);
    run_op(op);
    verify_regs(tag);
    if (st_chk) chk(tag, "stored word", dm_val(st_addr), st_data);
  endtask

  task automatic preload(input logic [15:0] sr);
    for (int i = 0; i < 32; i++) set_reg(i, 16'h1111 * 16'(i % 15) ^ 16'(i * 37));
    set_reg(19, sr);
  endtask

  task automatic t_reset;
    chk("R1", "ready", {15'd0, ready}, 16'd1);
    chk("R1", "strobes", {13'd0, dm_re, dm_we, im_re}, 16'd0);
    for (int i = 0; i < 32; i++) m[i] = 16'h0000;
    verify_regs("R1");
  endtask

  task automatic t_regport;
    set_reg(3, 16'hBEEF);
    set_reg(27, 16'h0F0F);
    preload(16'h0000);
    verify_regs("R11");
  endtask

  task automatic t_short;
    set_reg(18, 16'hC37E);
    for (int d = 0; d < 8; d++) run_check(op_sld(d, 8'(d * 37 + 5)), "R2");
    for (int s = 0; s < 8; s++) set_reg(24 + s, 16'hA000 + 16'(s * 3));
    run_check(op_sst(2, 8'hFF), "R3");
    run_check(op_sst(7, 8'h00), "R3");
    set_reg(18, 16'h0001);
    run_check(op_sst(5, 8'h40), "R3");
    run_check(op_sld(1, 8'h40), "R2");
    chk("R2", "reload of stored word", m[25], 16'hA00F);
  endtask

  task automatic t_indirect;
    logic [15:0] v;
    for (int ar = 0; ar < 4; ar++) begin
      for (int mode = 0; mode < 4; mode++) begin
        for (int st = 0; st < 2; st++) begin
          set_reg(ar, 16'h8000 + 16'(ar * 4099 + mode * 17));
          set_reg(4 + ar, (mode == 3 && ar[0]) ? 16'hFFF0 : 16'h0123);
          run_check(op_ind(mode, st, ar, 8 + ar * 4 + mode), "R4");
        end
      end
    end
    set_reg(0, 16'hFFFF);
    run_check(op_ind(2, 0, 0, 26), "R5");
    chk("R5", "inc wrap", m[0], 16'h0000);
    chk("R6", "pre-update address", m[26], dm_val(16'hFFFF));
    set_reg(1, 16'h0000);
    run_check(op_ind(1, 1, 1, 9), "R5");
    chk("R5", "dec wrap", m[1], 16'hFFFF);
    set_reg(2, 16'hFFF0); set_reg(6, 16'h0020);
    run_check(op_ind(3, 0, 2, 12), "R5");
    get_reg(2, v);
    chk("R5", "index wrap", v, 16'h0010);
    set_reg(3, 16'h0005); set_reg(7, 16'hFFF8);
    run_check(op_ind(3, 1, 3, 20), "R5");
    get_reg(3, v);
    chk("R5", "negative index", v, 16'hFFFD);
    set_reg(2, 16'h4000);
    run_check(op_ind(2, 0, 2, 2), "R6");
    chk("R6", "update wins on own register", m[2], 16'h4001);
    set_reg(2, 16'h4000);
    run_check(op_ind(0, 0, 2, 2), "R6");
  endtask

  task automatic t_pload;
    set_reg(19, 16'h0000);
    for (int acc = 0; acc < 2; acc++)
      for (int mode = 0; mode < 4; mode++) begin
        set_reg(mode, 16'h7FFE + 16'(mode * 9));
        set_reg(4 + mode, 16'hFF80);
        run_check(op_pld(acc, mode, mode), "R7");
      end
    set_reg(16, 16'h1234); set_reg(28, 16'h5678);
    set_reg(0, 16'h0000);
    run_check(op_pld(0, 0, 0), "R8");
    chk("R8", "high kept when mode off", m[16], 16'h1234);
  endtask

  task automatic t_widen;
    logic [15:0] v;
    set_reg(19, 16'h4000);
    set_reg(17, 16'h1234); set_reg(29, 16'h5678);
    set_reg(1, 16'h0000);
    run_check(op_pld(1, 0, 1), "R8");
    get_reg(17, v);
    chk("R8", "high filled with ones", v, 16'hFFFF);
    get_reg(29, v);
    chk("R8", "low cleared", v, 16'h0000);
    set_reg(16, 16'hAAAA); set_reg(28, 16'h5555);
    set_reg(0, 16'h0008);
    run_check(op_pld(0, 2, 0), "R8");
    chk("R8", "high filled with zeros", m[16], 16'h0000);
    set_reg(18, 16'h0055);
    set_reg(17, 16'h0F00); set_reg(29, 16'h00F0);
    run_check(op_sld(7, 8'h21), "R8");
  endtask

  task automatic t_timing;
    logic [15:0] op;
    set_reg(2, 16'h1234);
    op = op_ind(2, 0, 2, 24);
    model_exec(op);
    @(negedge clk);
    op_valid = 1'b1; op_word = op;
    @(posedge clk);
    @(negedge clk);
    op_valid = 1'b0;
    chk("R9", "read strobe after accept", {15'd0, dm_re}, 16'd1);
    chk("R9", "address", dm_addr, 16'h1234);
    chk("R9", "busy 1", {15'd0, ready}, 16'd0);
    @(negedge clk);
    chk("R9", "strobe single cycle", {15'd0, dm_re}, 16'd0);
    chk("R9", "busy 2", {15'd0, ready}, 16'd0);
    @(negedge clk);
    chk("R9", "ready again", {15'd0, ready}, 16'd1);
    verify_regs("R9");
  endtask

  task automatic t_illegal;
    logic [15:0] ops [3];
    ops[0] = 16'hFFFF; ops[1] = 16'h0380; ops[2] = 16'h1880;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      op_valid = 1'b1; op_word = ops[k];
      @(posedge clk);
      @(negedge clk);
      op_valid = 1'b0;
      chk("R10", "ready held", {15'd0, ready}, 16'd1);
      chk("R10", "no strobe", {13'd0, dm_re, dm_we, im_re}, 16'd0);
      verify_regs("R10");
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_regport();
    t_short();
    t_indirect();
    t_pload();
    t_widen();
    t_timing();
    t_illegal();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule